// File: doc/BRIEF.md
# Content-Addressed Bit-Serial SIMD Array

A row of identical processing units, each holding a wide local data word, a single-bit serial ALU and an activity tag. A controller sends one command at a time, and every unit sees the same command. The command carries a field position, a field length, scalar data, a care mask and one of four operations. A match compares each unit's field with the scalar, bit by bit. The units that agree on every cared-for bit either turn themselves on, or turn on their neighbour one step up or down the row. Later add, read and write commands act only on the units that are on. An add takes either the scalar or a second field of the same word as its operand.

All field work is bit-serial: one bit position per cycle, for every unit at once. Commands enter over a valid/ready handshake. The array accepts a command only when `cmd_valid` and `cmd_ready` are both high on a clock edge. `cmd_ready` then stays low while the bits are walked. The controller must hold the command stable while it waits, and may offer the next command as soon as `cmd_ready` rises again. A status pin reports whether any unit matched in the last match, and a result register holds the OR of the field over all units that were on during the last read.

Top module: `assoc_array`

## Requirements
- R1: After reset every unit's tag is on, every data word is zero, `cmd_ready` is 1, and `match_any`, `rd_data` and `done` are 0.
- R2: Operation codes on `cmd_op` are 0 match, 1 add, 2 read, 3 write. A command of length L accepted on an edge keeps `cmd_ready` low for exactly L+1 cycles. `done` is high for the one cycle in which `cmd_ready` returns.
- R3: A match sets a unit's match flag when its field (bit `cmd_start`+i of the word against bit i of `cmd_data`, for i below `cmd_len`) agrees on every bit i where `cmd_mask` bit i is 1. With `cmd_prop`=0 each unit's tag becomes its own flag.
- R4: With `cmd_prop`=1 a match sets unit j's tag to the flag of unit j-1 when `cmd_up`=1, or to the flag of unit j+1 when `cmd_up`=0. A unit with no such neighbour gets its tag cleared.
- R5: At the end of a match, `match_any` becomes 1 if at least one unit's match flag is set and 0 otherwise. This holds whatever the propagation mode, and the value stays until the next match ends.
- R6: A write stores the low `cmd_len` bits of `cmd_data` into the field of every unit whose tag is on. Units whose tag is off keep their word unchanged.
- R7: A scalar add (`cmd_vec`=0) replaces the field of each unit whose tag is on with (field + `cmd_data`) mod 2^`cmd_len`. Other units are unchanged.
- R8: A vector add (`cmd_vec`=1) replaces the field at `cmd_start` of each unit whose tag is on with (that field + the field at `cmd_src` of the same word) mod 2^`cmd_len`. The carry starts at zero in every add.
- R9: A read sets `rd_data` bit i to the OR, over all units whose tag is on, of field bit i. Bits at or above `cmd_len` are 0, and the whole result is 0 when no unit is on.
- R10: Add, read and write leave every tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Array can take a command this cycle |
| cmd_op | input | 2 | Operation code |
| cmd_start | input | POS_W | Lowest bit of the target field |
| cmd_len | input | LEN_W | Field length in bits, 1 to DATA_W |
| cmd_src | input | POS_W | Lowest bit of the second field for a vector add |
| cmd_vec | input | 1 | Add takes its operand from the second field |
| cmd_data | input | DATA_W | Broadcast scalar |
| cmd_mask | input | DATA_W | Per-bit care mask for match |
| cmd_prop | input | 1 | Match drives neighbour tags instead of own tag |
| cmd_up | input | 1 | Neighbour direction: 1 toward higher index |
| done | output | 1 | One-cycle pulse when a command completes |
| match_any | output | 1 | Some unit matched in the last match |
| rd_data | output | DATA_W | Result of the last read |

## Verification
The assertions take for granted that every offered command has a length from 1 to DATA_W. They also assume that its target field, and its source field for a vector add, fit inside the data word, and that a command held against low ready does not change. The stimulus offers a command only at a falling edge while `cmd_ready` is high, so it never holds one against back-pressure. It builds every field at a legal position of eight bits or less. Unit identities are written by a chain of upward-propagating matches and scalar adds, so every later check can pick a single unit by content.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  typedef enum logic [1:0] {
    OP_MATCH = 2'd0,
    OP_ADD   = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;
endpackage

// File: rtl/assoc_seq.sv
module assoc_seq
  import assoc_pkg::*;
#(
  parameter int WIDTH  = 200,
  parameter int DATA_W = 16,
  parameter int POS_W  = $clog2(WIDTH),
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [POS_W-1:0]  cmd_start,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [POS_W-1:0]  cmd_src,
  input  logic              cmd_vec,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic              cmd_prop,
  input  logic              cmd_up,
  output logic              clr,
  output logic              step,
  output logic              fin,
  output op_e               op,
  output logic [POS_W-1:0]  pos,
  output logic [POS_W-1:0]  src_pos,
  output logic              vec,
  output logic              dbit,
  output logic              mbit,
  output logic              prop,
  output logic              up,
  output logic [LEN_W-1:0]  idx
);
  logic              busy;
  logic [POS_W-1:0]  start_q, src_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] data_sh, mask_sh;

  assign cmd_ready = !busy;
  assign clr       = cmd_valid && !busy;
  assign step      = busy && !fin;
  assign pos       = start_q + POS_W'(idx);
  assign src_pos   = src_q + POS_W'(idx);
  assign dbit      = data_sh[0];
  assign mbit      = mask_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      fin     <= 1'b0;
      idx     <= '0;
      op      <= OP_MATCH;
      start_q <= '0;
      src_q   <= '0;
      len_q   <= '0;
      vec     <= 1'b0;
      prop    <= 1'b0;
      up      <= 1'b0;
      data_sh <= '0;
      mask_sh <= '0;
    end else if (clr) begin
      busy    <= 1'b1;
      fin     <= 1'b0;
      idx     <= '0;
      op      <= op_e'(cmd_op);
      start_q <= cmd_start;
      src_q   <= cmd_src;
      len_q   <= cmd_len;
      vec     <= cmd_vec;
      prop    <= cmd_prop;
      up      <= cmd_up;
      data_sh <= cmd_data;
      mask_sh <= cmd_mask;
    end else if (step) begin
      idx     <= idx + LEN_W'(1);
      data_sh <= data_sh >> 1;
      mask_sh <= mask_sh >> 1;
      if (idx == len_q - LEN_W'(1)) fin <= 1'b1;
    end else if (fin) begin
      busy <= 1'b0;
      fin  <= 1'b0;
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0 && int'(cmd_len) <= DATA_W)); // R2
  AST_FIELD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_start) + int'(cmd_len) <= WIDTH &&
                   (!cmd_vec || int'(cmd_src) + int'(cmd_len) <= WIDTH))); // R8
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                   $stable(cmd_data) && $stable(cmd_start))); // R2
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
  AST_STEP_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> idx < len_q); // R2
endmodule

// File: rtl/assoc_pe.sv
module assoc_pe
  import assoc_pkg::*;
#(
  parameter int WIDTH = 200,
  parameter int POS_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  op_e              op,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] src_pos,
  input  logic             vec,
  input  logic             dbit,
  input  logic             mbit,
  input  logic             tag_load,
  input  logic             tag_in,
  output logic             tag,
  output logic             flag,
  output logic             rd_bit
);
  logic [WIDTH-1:0] word;
  logic             carry;
  logic             cur, opnd, sum, cout;

  assign cur    = word[pos];
  assign opnd   = vec ? word[src_pos] : dbit;
  assign sum    = cur ^ opnd ^ carry;
  assign cout   = (cur & opnd) | (carry & (cur ^ opnd));
  assign rd_bit = tag & cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      tag   <= 1'b1;
      flag  <= 1'b0;
      carry <= 1'b0;
    end else begin
      if (clr) begin
        carry <= 1'b0;
        flag  <= 1'b1;
      end else if (step) begin
        unique case (op)
          OP_MATCH: if (mbit && (cur != dbit)) flag <= 1'b0;
          OP_ADD: if (tag) begin
            word[pos] <= sum;
            carry     <= cout;
          end
          OP_WRITE: if (tag) word[pos] <= dbit;
          default: ;
        endcase
      end
      if (tag_load) tag <= tag_in;
    end
  end

  AST_IDLE_UNIT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tag) |=> $stable(word)); // R6
  AST_MISMATCH_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !flag) |=> !flag); // R3
endmodule

// File: rtl/assoc_array.sv
module assoc_array
  import assoc_pkg::*;
#(
  parameter int NUM_PE = 16,
  parameter int WIDTH  = 200,
  parameter int DATA_W = 16,
  parameter int POS_W  = $clog2(WIDTH),
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [POS_W-1:0]  cmd_start,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [POS_W-1:0]  cmd_src,
  input  logic              cmd_vec,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic              cmd_prop,
  input  logic              cmd_up,
  output logic              done,
  output logic              match_any,
  output logic [DATA_W-1:0] rd_data
);
  logic             clr, step, fin, vec, dbit, mbit, prop, up, tag_load;
  op_e              op;
  logic [POS_W-1:0] pos, src_pos;
  logic [LEN_W-1:0] idx;
  logic [NUM_PE-1:0] tag_vec, flag_vec, rd_vec, tag_in;

  assoc_seq #(.WIDTH(WIDTH), .DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_start(cmd_start), .cmd_len(cmd_len), .cmd_src(cmd_src),
    .cmd_vec(cmd_vec), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .cmd_prop(cmd_prop), .cmd_up(cmd_up),
    .clr(clr), .step(step), .fin(fin), .op(op), .pos(pos), .src_pos(src_pos),
    .vec(vec), .dbit(dbit), .mbit(mbit), .prop(prop), .up(up), .idx(idx)
  );

  assign tag_load = fin && (op == OP_MATCH);

  for (genvar j = 0; j < NUM_PE; j++) begin : g_unit
    logic from_below, from_above;
    if (j == 0) begin : g_low
      assign from_below = 1'b0;
    end else begin : g_mid_lo
      assign from_below = flag_vec[j-1];
    end
    if (j == NUM_PE - 1) begin : g_high
      assign from_above = 1'b0;
    end else begin : g_mid_hi
      assign from_above = flag_vec[j+1];
    end
    assign tag_in[j] = prop ? (up ? from_below : from_above) : flag_vec[j];

    assoc_pe #(.WIDTH(WIDTH), .POS_W(POS_W)) u_pe (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .op(op),
      .pos(pos), .src_pos(src_pos), .vec(vec), .dbit(dbit), .mbit(mbit),
      .tag_load(tag_load), .tag_in(tag_in[j]),
      .tag(tag_vec[j]), .flag(flag_vec[j]), .rd_bit(rd_vec[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      match_any <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= fin;
      if (tag_load) match_any <= |flag_vec;
      if (clr && (op_e'(cmd_op) == OP_READ)) rd_data <= '0;
      else if (step && (op == OP_READ) && (|rd_vec))
        rd_data <= rd_data | (DATA_W'(1) << idx);
    end
  end

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R2
  AST_STATUS_ONLY_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_load |=> $stable(match_any)); // R5
  AST_TAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_load |=> $stable(tag_vec)); // R10
  AST_RESULT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ && !clr) |=> $stable(rd_data)); // R9
endmodule

// File: tb/assoc_array_tb.sv
module assoc_array_tb;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int DW = 8;
  localparam int PW = $clog2(W);
  localparam int LW = $clog2(DW + 1);
  localparam int F_ID = 0, F_B = 8, F_C = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_vec = 1'b0, cmd_prop = 1'b0, cmd_up = 1'b0;
  logic cmd_ready, done, match_any;
  logic [1:0] cmd_op = '0;
  logic [PW-1:0] cmd_start = '0, cmd_src = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [DW-1:0] cmd_data = '0, cmd_mask = '0, rd_data;

  int n_chk = 0, n_fail = 0;
  int b_val [N];
  int c_val [N];

  always #5 clk = ~clk;

  assoc_array #(.NUM_PE(N), .WIDTH(W), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_start(cmd_start), .cmd_len(cmd_len), .cmd_src(cmd_src),
    .cmd_vec(cmd_vec), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .cmd_prop(cmd_prop), .cmd_up(cmd_up),
    .done(done), .match_any(match_any), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int op, input int start, input int len, input int src,
                        input bit vec, input int data, input int mask,
                        input bit prop, input bit up);
    int busy_cycles;
    @(negedge clk);
    cmd_op = 2'(op); cmd_start = PW'(start); cmd_len = LW'(len); cmd_src = PW'(src);
    cmd_vec = vec; cmd_data = DW'(data); cmd_mask = DW'(mask);
    cmd_prop = prop; cmd_up = up; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_cycles = 0;
    while (!cmd_ready && busy_cycles < 100) begin
      busy_cycles++;
      @(negedge clk);
    end
    check("R2 busy cycles", busy_cycles, len + 1);
    check("R2 done pulse", int'(done), 1);
  endtask

  task automatic pick(input int id);
    run_op(0, F_ID, 8, 0, 0, id, 8'hFF, 0, 0);
  endtask

  task automatic read_field(input int start, input int len, output int val);
    run_op(2, start, len, 0, 0, 0, 0, 0, 0);
    val = int'(rd_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, exp_or, exp_any;
    int masks [4];
    masks = '{8'hFF, 8'hFE, 8'hFC, 8'hF9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(cmd_ready), 1);
    check("R1 match_any", int'(match_any), 0);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 done", int'(done), 0);
    read_field(F_ID, 8, v);
    check("R1 words zero", v, 0);
    // R1: every tag on after reset, so this write reaches all units
    run_op(3, F_B, 8, 0, 0, 8'h3C, 0, 0, 0);
    for (int j = 0; j < N; j++) b_val[j] = 8'h3C;

    // Build identities: match id==k-1 passed upward, then add 1 (R4, R7)
    for (int k = 1; k < N; k++) begin
      run_op(0, F_ID, 8, 0, 0, k - 1, 8'hFF, 1, 1);
      check("R5 any during build", int'(match_any), 1);
      run_op(1, F_ID, 8, 0, 0, 1, 0, 0, 0);
    end

    for (int j = 0; j < N; j++) begin
      pick(j);
      check("R5 single match", int'(match_any), 1);
      read_field(F_ID, 8, v);
      check("R3 selected identity", v, j);
      read_field(F_B, 8, v);
      check("R1 broadcast write reached unit", v, 8'h3C);
    end

    pick(N);
    check("R5 no match", int'(match_any), 0);
    read_field(F_ID, 8, v);
    check("R9 empty read", v, 0);

    // R3/R9 masked match sweep
    foreach (masks[m]) begin
      for (int d = 0; d < N; d++) begin
        exp_or = 0; exp_any = 0;
        for (int j = 0; j < N; j++)
          if (((j ^ d) & masks[m]) == 0) begin exp_or |= j; exp_any = 1; end
        run_op(0, F_ID, 8, 0, 0, d, masks[m], 0, 0);
        check("R5 masked any", int'(match_any), exp_any);
        read_field(F_ID, 8, v);
        check("R3 R9 masked OR", v, exp_or);
      end
    end

    // R4 propagation
    run_op(0, F_ID, 8, 0, 0, 3, 8'hFF, 1, 0);
    read_field(F_ID, 8, v);
    check("R4 down neighbour", v, 2);
    run_op(0, F_ID, 8, 0, 0, 3, 8'hFF, 1, 1);
    read_field(F_ID, 8, v);
    check("R4 up neighbour", v, 4);
    run_op(0, F_ID, 8, 0, 0, N - 1, 8'hFF, 1, 1);
    check("R5 any with propagation", int'(match_any), 1);
    read_field(F_ID, 8, v);
    check("R4 top edge cleared", v, 0);
    run_op(0, F_ID, 8, 0, 0, 0, 8'hFF, 1, 0);
    read_field(F_ID, 8, v);
    check("R4 bottom edge cleared", v, 0);

    // R6 write only the active unit, R10 tag survives the write
    pick(5);
    run_op(3, F_B, 8, 0, 0, 8'hA5, 0, 0, 0);
    b_val[5] = 8'hA5;
    read_field(F_ID, 8, v);
    check("R10 tag kept after write", v, 5);
    for (int j = 0; j < N; j++) begin
      pick(j);
      read_field(F_B, 8, v);
      check("R6 write confined", v, b_val[j]);
    end

    // R8 vector add sweep with carry wrap
    foreach (masks[s]) begin
      v = (s == 0) ? 0 : (s == 1) ? 100 : (s == 2) ? 250 : 255;
      run_op(0, F_ID, 8, 0, 0, 0, 0, 0, 0);
      run_op(3, F_C, 8, 0, 0, v, 0, 0, 0);
      run_op(1, F_C, 8, F_ID, 1, 0, 0, 0, 0);
      for (int j = 0; j < N; j++) c_val[j] = (v + j) & 8'hFF;
      for (int j = 0; j < N; j++) begin
        pick(j);
        read_field(F_C, 8, v);
        check("R8 vector add", v, c_val[j]);
      end
    end

    // R7 scalar add on all, then on one unit only
    run_op(0, F_ID, 8, 0, 0, 0, 0, 0, 0);
    run_op(1, F_C, 8, 0, 0, 8'h81, 0, 0, 0);
    for (int j = 0; j < N; j++) c_val[j] = (c_val[j] + 8'h81) & 8'hFF;
    pick(2);
    run_op(1, F_C, 8, 0, 0, 1, 0, 0, 0);
    c_val[2] = (c_val[2] + 1) & 8'hFF;
    for (int j = 0; j < N; j++) begin
      pick(j);
      read_field(F_C, 8, v);
      check("R7 scalar add", v, c_val[j]);
    end

    // R9 short field: bits above length zero; R2 short timing
    run_op(0, F_ID, 8, 0, 0, 0, 0, 0, 0);
    run_op(0, F_C, 8, 0, 0, 0, 0, 0, 0);
    read_field(F_C + 4, 3, v);
    exp_or = 0;
    for (int j = 0; j < N; j++) exp_or |= (c_val[j] >> 4) & 7;
    check("R9 short read", v, exp_or);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule